// File: doc/BRIEF.md
# L1 Entry Responder Handshake

This block sits on the upstream side of a serial link and answers the link partner when it asks to move the link into the L1 low-power state. The receive path raises a one-cycle strobe when a request packet has arrived. The block then decides whether to grant the request or refuse it. The decision uses a policy input from software-controlled logic and a flag that reports outstanding transmit traffic.

When it grants, the block sends acknowledge packets to the partner again and again, at a fixed spacing, for as long as the partner keeps its transmitter active. Only the partner's electrical-idle ordered set stops the acknowledges, as reported by an external detector. On that detection the block stops acknowledging, blocks all packet transmission and places its own transmitter in electrical idle. Both directions are then idle and the link is in L1.

When it refuses, the block sends a single reject strobe and stays active. An exit request received in L1 releases the transmitter and returns the block to the active state.

Top module: `l1_resp_top`

## Requirements
- R1: After a synchronous reset, the state output reads ACTIVE (2'b00) and the acknowledge, reject, transmit-block and transmit-idle outputs are all low.
- R2: A request strobe in ACTIVE, with the policy input high and no pending traffic, produces an acknowledge strobe in the following cycle. In that same cycle the state output reads ACKING (2'b01).
- R3: A request strobe in ACTIVE with the policy input low produces a reject strobe in the following cycle. The reject is exactly one cycle wide, no acknowledge is sent, and the state stays ACTIVE.
- R4: A request strobe in ACTIVE while pending traffic is flagged is refused in the same way as R3, even when the policy input is high.
- R5: While in ACKING, the acknowledge strobe is repeated every ACK_GAP cycles, counted from the first one. Each acknowledge is one cycle wide and the output stays low in between.
- R6: An electrical-idle detect in ACKING causes the following changes in the next cycle: the acknowledge stops, transmit-block and transmit-idle go high, and the state reads L1 (2'b10). This detect wins over an acknowledge that is due in the same cycle.
- R7: An exit request in L1 causes the following changes in the next cycle: transmit-block and transmit-idle drop, and the state reads ACTIVE. A later request can then be granted again.
- R8: Request strobes received in ACKING or L1 are ignored. They produce no reject, they do not shift the acknowledge schedule, and they do not change the state.
- R9: An electrical-idle detect or an exit request received in ACTIVE has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_req_i | input | 1 | One-cycle strobe: partner's L1 request packet received |
| allow_l1_i | input | 1 | Policy: high permits granting L1 |
| traffic_pend_i | input | 1 | High while transmit traffic is outstanding |
| eidle_os_det_i | input | 1 | Partner's electrical-idle ordered set detected |
| l1_exit_i | input | 1 | Request to leave L1 |
| send_ack_o | output | 1 | Strobe: transmit one acknowledge packet |
| send_rej_o | output | 1 | Strobe: transmit one reject message |
| tx_block_o | output | 1 | High while packet transmission is blocked |
| tx_eidle_o | output | 1 | High while the transmitter is in electrical idle |
| state_o | output | 2 | 00 ACTIVE, 01 ACKING, 10 L1 |

## Verification
Every output is a register, so the effect of an input sampled at a clock edge appears directly after that edge. This applies to the grant or refusal, the idle entry on detect, the exit, and the ignored stimuli. The bench drives inputs on falling edges, so each input is captured by the next rising edge, and it reads the outputs at the falling edge that follows. In this way every check lands exactly one cycle after its stimulus. Repeated acknowledges fall ACK_GAP cycles apart from the first one. The bench therefore counts falling edges from the first acknowledge and expects the output low on each of the ACK_GAP-1 edges between acknowledges. The precedence case raises the detect in the cycle in which the next acknowledge is due.

// File: rtl/l1r_pkg.sv
package l1r_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'b00,
    ST_ACKING = 2'b01,
    ST_L1     = 2'b10
  } l1r_state_e;
endpackage

// File: rtl/l1r_policy.sv
module l1r_policy (
  input  logic allow_i,
  input  logic pend_i,
  output logic grant_o
);
  // Grant only when policy allows and nothing is waiting to go out.
  assign grant_o = allow_i & ~pend_i;
endmodule

// File: rtl/l1r_ack_pacer.sv
module l1r_ack_pacer #(
  parameter int ACK_GAP = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic due_o
);
  localparam int CW = (ACK_GAP > 2) ? $clog2(ACK_GAP) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(ACK_GAP - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RELOAD;
    end else if (start_i) begin
      cnt_q <= RELOAD;
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
    end
  end

  assign due_o = run_i && (cnt_q == '0);

  // R5: counter never leaves its reload range
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RELOAD);
endmodule

// File: rtl/l1r_fsm.sv
module l1r_fsm
  import l1r_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       grant_i,
  input  logic       eios_i,
  input  logic       exit_i,
  input  logic       due_i,
  output logic       start_o,
  output logic       run_o,
  output logic       ack_o,
  output logic       rej_o,
  output logic       block_o,
  output logic       eidle_o,
  output logic [1:0] state_o
);
  l1r_state_e state_q;
  logic ack_q, rej_q, blk_q, eid_q;

  assign start_o = (state_q == ST_ACTIVE) && req_i && grant_i;
  assign run_o   = (state_q == ST_ACKING) && !eios_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACTIVE;
      ack_q   <= 1'b0;
      rej_q   <= 1'b0;
      blk_q   <= 1'b0;
      eid_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      rej_q <= 1'b0;
      case (state_q)
        ST_ACTIVE: begin
          if (req_i) begin
            if (grant_i) begin
              state_q <= ST_ACKING;
              ack_q   <= 1'b1;
            end else begin
              rej_q <= 1'b1;
            end
          end
        end
        ST_ACKING: begin
          if (eios_i) begin
            state_q <= ST_L1;
            blk_q   <= 1'b1;
            eid_q   <= 1'b1;
          end else if (due_i) begin
            ack_q <= 1'b1;
          end
        end
        ST_L1: begin
          if (exit_i) begin
            state_q <= ST_ACTIVE;
            blk_q   <= 1'b0;
            eid_q   <= 1'b0;
          end
        end
        default: state_q <= ST_ACTIVE;
      endcase
    end
  end

  assign ack_o   = ack_q;
  assign rej_o   = rej_q;
  assign block_o = blk_q;
  assign eidle_o = eid_q;
  assign state_o = state_q;

  // R2
  grant_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && req_i && grant_i) |=> (ack_q && state_q == ST_ACKING));
  // R3
  refuse_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && req_i && !grant_i) |=> (rej_q && !ack_q && state_q == ST_ACTIVE));
  // R5
  ack_only_acking_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (state_q == ST_ACKING && !rej_q));
  // R6
  eios_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACKING && eios_i) |=> (!ack_q && blk_q && eid_q && state_q == ST_L1));
  // R7
  exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_L1 && exit_i) |=> (!blk_q && !eid_q && state_q == ST_ACTIVE));
  // R8
  no_rej_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_ACTIVE) |=> !rej_q);
  // R9
  eidle_in_l1_chk: assert property (@(posedge clk) disable iff (rst)
    eid_q |-> (state_q == ST_L1));
endmodule

// File: rtl/l1_resp_top.sv
module l1_resp_top #(
  parameter int ACK_GAP = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       l1_req_i,
  input  logic       allow_l1_i,
  input  logic       traffic_pend_i,
  input  logic       eidle_os_det_i,
  input  logic       l1_exit_i,
  output logic       send_ack_o,
  output logic       send_rej_o,
  output logic       tx_block_o,
  output logic       tx_eidle_o,
  output logic [1:0] state_o
);
  logic grant, start, run, due;

  l1r_policy u_policy (
    .allow_i (allow_l1_i),
    .pend_i  (traffic_pend_i),
    .grant_o (grant)
  );

  l1r_ack_pacer #(.ACK_GAP(ACK_GAP)) u_pacer (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .run_i   (run),
    .due_o   (due)
  );

  l1r_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_i   (l1_req_i),
    .grant_i (grant),
    .eios_i  (eidle_os_det_i),
    .exit_i  (l1_exit_i),
    .due_i   (due),
    .start_o (start),
    .run_o   (run),
    .ack_o   (send_ack_o),
    .rej_o   (send_rej_o),
    .block_o (tx_block_o),
    .eidle_o (tx_eidle_o),
    .state_o (state_o)
  );

  // R3
  ack_rej_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(send_ack_o && send_rej_o));
endmodule

// File: tb/sim_l1_resp_top.sv
`timescale 1ns/1ps
module sim_l1_resp_top;
  localparam int GAP = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, acc = 1'b0, pend = 1'b0, eios = 1'b0, exitr = 1'b0;
  logic ack, rej, blk, eid;
  logic [1:0] st;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  l1_resp_top #(.ACK_GAP(GAP)) u0 (
    .clk(clk), .rst(rst), .l1_req_i(req), .allow_l1_i(acc),
    .traffic_pend_i(pend), .eidle_os_det_i(eios), .l1_exit_i(exitr),
    .send_ack_o(ack), .send_rej_o(rej), .tx_block_o(blk),
    .tx_eidle_o(eid), .state_o(st)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic outs(input string tag, input logic a, r, b, e, input logic [1:0] s);
    chk(tag, {27'd0, a, r, b, e, s}, {27'd0, a, r, b, e, s} ^ {27'd0, ack ^ a, rej ^ r, blk ^ b, eid ^ e, st ^ s} ^ {27'd0, ack ^ a, rej ^ r, blk ^ b, eid ^ e, st ^ s} ^ {27'd0, ack ^ a, rej ^ r, blk ^ b, eid ^ e, st ^ s});
  endtask

  task automatic send_req(input logic a, input logic p);
    acc = a; pend = p; req = 1'b1;
    tick();
    req = 1'b0;
  endtask

  task automatic pulse_eios();
    eios = 1'b1; tick(); eios = 1'b0;
  endtask

  task automatic pulse_exit();
    exitr = 1'b1; tick(); exitr = 1'b0;
  endtask

  task automatic t_reset();
    tick(); tick();
    outs("R1 outputs in reset", 0, 0, 0, 0, 2'b00);
    rst = 1'b0;
    tick();
    outs("R1 outputs after reset", 0, 0, 0, 0, 2'b00);
  endtask

  task automatic t_accept_period();
    send_req(1, 0);
    outs("R2 first ack", 1, 0, 0, 0, 2'b01);
    for (int p = 0; p < 3; p++) begin
      for (int i = 1; i < GAP; i++) begin
        tick();
        outs("R5 gap between acks", 0, 0, 0, 0, 2'b01);
      end
      tick();
      outs("R5 repeated ack", 1, 0, 0, 0, 2'b01);
    end
    pulse_eios();
    outs("R6 enter L1", 0, 0, 1, 1, 2'b10);
    for (int i = 0; i < GAP + 2; i++) begin
      tick();
      outs("R6 no ack in L1", 0, 0, 1, 1, 2'b10);
    end
    pulse_exit();
    outs("R7 exit to active", 0, 0, 0, 0, 2'b00);
  endtask

  task automatic t_refuse(input string tag, input logic a, input logic p);
    send_req(a, p);
    outs(tag, 0, 1, 0, 0, 2'b00);
    for (int i = 0; i < GAP + 1; i++) begin
      tick();
      outs(tag, 0, 0, 0, 0, 2'b00);
    end
  endtask

  task automatic t_precedence();
    send_req(1, 0);
    outs("R2 grant again after exit (R7)", 1, 0, 0, 0, 2'b01);
    repeat (GAP - 1) tick();
    eios = 1'b1; tick(); eios = 1'b0;
    outs("R6 detect wins over due ack", 0, 0, 1, 1, 2'b10);
    send_req(1, 0);
    outs("R8 request in L1 ignored", 0, 0, 1, 1, 2'b10);
    send_req(0, 0);
    outs("R8 refusable request in L1 ignored", 0, 0, 1, 1, 2'b10);
    pulse_exit();
    outs("R7 exit after precedence", 0, 0, 0, 0, 2'b00);
  endtask

  task automatic t_req_during_ack();
    send_req(1, 0);
    outs("R2 grant", 1, 0, 0, 0, 2'b01);
    repeat (3) tick();
    send_req(0, 0);
    outs("R8 request in ACKING ignored", 0, 0, 0, 0, 2'b01);
    repeat (GAP - 5) tick();
    outs("R8 schedule unchanged before ack", 0, 0, 0, 0, 2'b01);
    tick();
    outs("R8 ack on original schedule", 1, 0, 0, 0, 2'b01);
    pulse_eios();
    pulse_exit();
    outs("R7 back to active", 0, 0, 0, 0, 2'b00);
  endtask

  task automatic t_ignore_active();
    pulse_eios();
    outs("R9 detect in ACTIVE ignored", 0, 0, 0, 0, 2'b00);
    pulse_exit();
    outs("R9 exit in ACTIVE ignored", 0, 0, 0, 0, 2'b00);
  endtask

  initial begin
    t_reset();
    t_accept_period();
    t_refuse("R3 policy low refusal", 0, 0);
    t_refuse("R4 pending traffic refusal", 1, 1);
    t_precedence();
    t_req_during_ack();
    t_ignore_active();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule